// File: doc/BRIEF.md
# Rank Interleave Decoder

This block turns a channel-local memory address into the physical rank that holds it. It returns the DIMM slot, the rank inside that DIMM, the combined channel rank number and the address as seen inside the rank. Software first loads a small table through a write port. The table holds range entries, each with a valid bit, an upper bound and a power-of-two way count. It also holds four way registers per range, each giving a channel rank and an offset. A single page-policy bit picks the address bit on which ranks interleave.

A lookup starts with a one-cycle `start` pulse that carries the address. The block checks one range entry per clock, in index order. Each entry's lower bound is the upper bound of the entry before it, and the first entry's lower bound is zero. On a hit, the block divides out the interleave, fetches the selected way register from a small synchronous RAM, subtracts the offset and raises `done_o` for one cycle. If no entry matches, `done_o` rises with `miss_o` set. Results stay on the outputs until the next lookup completes.

Top module: `rid_decoder`

## Requirements
- R1: After reset, `done_o` and `miss_o` are 0, and `dimm_o`, `rank_o`, `chan_rank_o` and `rank_addr_o` are all 0. All range entries are invalid after reset.
- R2: A write with `wr_kind`=0 loads range entry `wr_range`. Bit 31 is the valid bit. Bits 29:28 are the ways code, giving 1, 2, 4 or 8 ways. Bits 11:1 are the limit field, and the entry's upper bound is (field << 29) with the low 29 bits set to one. A write with `wr_kind`=1 loads way slot `wr_way` of range `wr_range`. Bits 15:2 of that write are the offset field, scaled by 2^26, and bits 19:16 are the channel rank. A write with `wr_kind`=2 sets close-page mode from bit 0.
- R3: Entries are tried in index order 0 upward, and the first match wins. An entry matches when it is valid and lower ≤ addr ≤ upper. The lower bound starts at 0 and becomes each entry's upper bound after that entry, whether or not the entry is valid.
- R4: The interleave shift is 6 in close-page mode and 13 in open-page mode.
- R5: The way index is (addr >> shift) mod ways. It selects way slot (index mod 4) of the matched range, so with 8 ways, indices 4 to 7 share slots 0 to 3.
- R6: `rank_addr_o` = ((((addr >> shift) / ways) << shift) | (addr mod 2^shift)) − offset, taken modulo 2^40.
- R7: `chan_rank_o` is the channel rank of the selected slot. `dimm_o` is `chan_rank_o` / 4 and `rank_o` is `chan_rank_o` mod 4.
- R8: When no entry matches, `done_o` rises with `miss_o`=1 and all result outputs are 0. On a hit, `miss_o`=0.
- R9: `done_o` is a one-cycle pulse. For a hit on entry k, it is high in the (k+2)th cycle after the clock edge that accepted `start`. For a miss, it is high in the 4th cycle after that edge.
- R10: A `start` that arrives while a lookup is in progress is ignored. It neither changes that lookup's result nor causes a further `done_o`.
- R11: Result outputs hold their values after `done_o` until the next lookup completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 range entry, 1 way slot, 2 page mode |
| wr_range | input | 2 | Range entry index for the write |
| wr_way | input | 2 | Way slot index for the write |
| wr_data | input | 32 | Write data |
| start | input | 1 | Begin a lookup of `addr_i` |
| addr_i | input | 40 | Channel-local address |
| done_o | output | 1 | Lookup complete pulse |
| miss_o | output | 1 | No range matched |
| dimm_o | output | 2 | DIMM slot |
| rank_o | output | 2 | Rank inside the DIMM |
| chan_rank_o | output | 4 | Channel rank number |
| rank_addr_o | output | 40 | Rank-local address |

## Verification
Lookups are run in open-page and close-page mode on the same address, which shows whether the shift actually follows the mode bit. The ways code is swept over all four values on one range, so that quotient and way selection are tested for every divisor, including the 8-way aliasing of slots. Addresses placed exactly on an upper bound and one above it, together with an invalid first entry, separate inclusive from exclusive bounds. They also show whether an invalid entry's bound is still carried forward, and the measured latency tells which entry actually matched. An offset larger than the quotient address checks the wrap, and a second start sent mid-lookup checks that it is ignored.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_LOOK = 2'd2
  } rid_state_e;

  localparam logic [1:0] WK_RANGE = 2'd0;
  localparam logic [1:0] WK_WAY   = 2'd1;
  localparam logic [1:0] WK_MODE  = 2'd2;

  // range entry word fields
  localparam int RE_VALID_BIT = 31;
  localparam int RE_WAYS_LO   = 28;
  localparam int RE_LIM_LO    = 1;

  // way slot word fields
  localparam int WS_OFF_LO  = 2;
  localparam int WS_RANK_LO = 16;

  localparam int SHIFT_CLOSE = 6;
  localparam int SHIFT_OPEN  = 13;
endpackage

// File: rtl/rid_range_table.sv
module rid_range_table
  import rid_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 40,
  parameter int LIMIT_LSB  = 29,
  parameter int LIMIT_W    = 11,
  parameter int RIDX_W     = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RIDX_W-1:0] widx,
  input  logic [31:0]       wdata,
  input  logic [RIDX_W-1:0] ridx,
  output logic              valid_o,
  output logic [ADDR_W-1:0] upper_o,
  output logic [1:0]        ways_code_o
);
  logic [NUM_RANGES-1:0] vld_q;
  logic [LIMIT_W-1:0]    lim_q  [NUM_RANGES];
  logic [1:0]            code_q [NUM_RANGES];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g]  <= 1'b0;
        lim_q[g]  <= '0;
        code_q[g] <= '0;
      end else if (we && widx == RIDX_W'(g)) begin
        vld_q[g]  <= wdata[RE_VALID_BIT];
        lim_q[g]  <= wdata[RE_LIM_LO +: LIMIT_W];
        code_q[g] <= wdata[RE_WAYS_LO +: 2];
      end
    end
  end

  always_comb begin
    valid_o     = vld_q[ridx];
    upper_o     = ADDR_W'({lim_q[ridx], {LIMIT_LSB{1'b1}}});
    ways_code_o = code_q[ridx];
  end
endmodule

// File: rtl/rid_way_mem.sv
module rid_way_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rid_split.sv
module rid_split
  import rid_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              close_page,
  input  logic [1:0]        ways_code,
  output logic [2:0]        way_idx,
  output logic [ADDR_W-1:0] quot_addr
);
  logic [4:0]        sh;
  logic [ADDR_W-1:0] q;
  logic [ADDR_W-1:0] low;
  logic [3:0]        mask;

  always_comb begin
    sh        = close_page ? 5'(SHIFT_CLOSE) : 5'(SHIFT_OPEN);
    q         = addr >> sh;
    mask      = (4'd1 << ways_code) - 4'd1;
    way_idx   = q[2:0] & mask[2:0];
    low       = addr & ~({ADDR_W{1'b1}} << sh);
    quot_addr = ((q >> ways_code) << sh) | low;
  end
endmodule

// File: rtl/rid_decoder.sv
module rid_decoder
  import rid_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int WAY_SLOTS  = 4,
  parameter int ADDR_W     = 40,
  parameter int LIMIT_LSB  = 29,
  parameter int OFF_LSB    = 26,
  parameter int OFF_W      = 14,
  parameter int CRANK_W    = 4,
  parameter int RIDX_W     = $clog2(NUM_RANGES),
  parameter int WIDX_W     = $clog2(WAY_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [RIDX_W-1:0] wr_range,
  input  logic [WIDX_W-1:0] wr_way,
  input  logic [31:0]       wr_data,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic              miss_o,
  output logic [1:0]        dimm_o,
  output logic [1:0]        rank_o,
  output logic [CRANK_W-1:0] chan_rank_o,
  output logic [ADDR_W-1:0] rank_addr_o
);
  localparam int LIMIT_W = ADDR_W - LIMIT_LSB;
  localparam int MEM_D   = NUM_RANGES * WAY_SLOTS;
  localparam int MEM_AW  = RIDX_W + WIDX_W;

  rid_state_e        state_q;
  logic [RIDX_W-1:0] idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] lower_q;
  logic [ADDR_W-1:0] quot_q;
  logic              close_q;
  logic              mode_q;

  logic              ent_valid;
  logic [ADDR_W-1:0] ent_upper;
  logic [1:0]        ent_code;
  logic              hit;
  logic [2:0]        way_idx;
  logic [ADDR_W-1:0] quot_addr;
  logic [31:0]       slot_word;
  logic              mem_re;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (wr_en && wr_kind == WK_MODE) mode_q <= wr_data[0];
  end

  rid_range_table #(
    .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W),
    .LIMIT_LSB(LIMIT_LSB), .LIMIT_W(LIMIT_W), .RIDX_W(RIDX_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .we(wr_en && wr_kind == WK_RANGE), .widx(wr_range), .wdata(wr_data),
    .ridx(idx_q), .valid_o(ent_valid), .upper_o(ent_upper),
    .ways_code_o(ent_code)
  );

  rid_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(addr_q), .close_page(close_q), .ways_code(ent_code),
    .way_idx(way_idx), .quot_addr(quot_addr)
  );

  always_comb hit = ent_valid && (addr_q >= lower_q) && (addr_q <= ent_upper);
  always_comb mem_re = (state_q == ST_SCAN) && hit;

  rid_way_mem #(.DEPTH(MEM_D), .DW(32), .AW(MEM_AW)) u_slots (
    .clk(clk),
    .we(wr_en && wr_kind == WK_WAY), .waddr({wr_range, wr_way}), .wdata(wr_data),
    .re(mem_re), .raddr({idx_q, way_idx[WIDX_W-1:0]}), .rdata(slot_word)
  );

  always_comb offset = ADDR_W'(slot_word[WS_OFF_LO +: OFF_W]) << OFF_LSB;

  logic unused_bits;
  always_comb unused_bits = ^{slot_word[31:20], slot_word[1:0], way_idx[2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      addr_q      <= '0;
      lower_q     <= '0;
      quot_q      <= '0;
      close_q     <= 1'b0;
      done_o      <= 1'b0;
      miss_o      <= 1'b0;
      dimm_o      <= '0;
      rank_o      <= '0;
      chan_rank_o <= '0;
      rank_addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= addr_i;
            close_q <= mode_q;
            idx_q   <= '0;
            lower_q <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            quot_q  <= quot_addr;
            state_q <= ST_LOOK;
          end else if (idx_q == RIDX_W'(NUM_RANGES - 1)) begin
            done_o      <= 1'b1;
            miss_o      <= 1'b1;
            dimm_o      <= '0;
            rank_o      <= '0;
            chan_rank_o <= '0;
            rank_addr_o <= '0;
            state_q     <= ST_IDLE;
          end else begin
            lower_q <= ent_upper;
            idx_q   <= idx_q + 1'b1;
          end
        end
        ST_LOOK: begin
          done_o      <= 1'b1;
          miss_o      <= 1'b0;
          chan_rank_o <= slot_word[WS_RANK_LO +: CRANK_W];
          dimm_o      <= slot_word[WS_RANK_LO + 2 +: 2];
          rank_o      <= slot_word[WS_RANK_LO +: 2];
          rank_addr_o <= quot_q - offset;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_look_done_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK) |=> (done_o && !miss_o));
  assert_miss_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(miss_o) |-> done_o);
  assert_addr_held_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(addr_q));
  assert_quot_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN) |-> (quot_addr <= addr_q));
  assert_way_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN) |-> ((way_idx >> ent_code) == 3'd0));
endmodule

// File: tb/rid_decoder_test.sv
module rid_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_kind;
  logic [1:0]  wr_range;
  logic [1:0]  wr_way;
  logic [31:0] wr_data;
  logic        start;
  logic [39:0] addr_i;
  logic        done_o, miss_o;
  logic [1:0]  dimm_o, rank_o;
  logic [3:0]  chan_rank_o;
  logic [39:0] rank_addr_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] sh_ctrl [4];
  logic [31:0] sh_slot [4][4];
  logic        sh_close;

  always #10 clk = ~clk;

  rid_decoder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_range(wr_range), .wr_way(wr_way), .wr_data(wr_data),
    .start(start), .addr_i(addr_i), .done_o(done_o), .miss_o(miss_o),
    .dimm_o(dimm_o), .rank_o(rank_o), .chan_rank_o(chan_rank_o),
    .rank_addr_o(rank_addr_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input int r, input int w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_range = 2'(r); wr_way = 2'(w); wr_data = d;
    if (k == 2'd0) sh_ctrl[r] = d;
    else if (k == 2'd1) sh_slot[r][w] = d;
    else sh_close = d[0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rng(input bit v, input int code, input int lim);
    return {v, 1'b0, 2'(code), 16'd0, 11'(lim), 1'b0};
  endfunction

  function automatic logic [31:0] slot(input int off, input int cr);
    return {12'd0, 4'(cr), 14'(off), 2'b0};
  endfunction

  task automatic model(input logic [39:0] a, output bit hit, output int k,
                       output logic [39:0] ra, output logic [3:0] cr);
    logic [39:0] lower, upper, q, pre, off;
    int sh, code, way;
    lower = 0; hit = 0; k = 0; ra = 0; cr = 0;
    for (int i = 0; i < 4; i++) begin
      upper = {sh_ctrl[i][11:1], 29'h1FFFFFFF};
      if (!hit && sh_ctrl[i][31] && a >= lower && a <= upper) begin
        hit = 1; k = i;
      end
      lower = upper;
    end
    if (hit) begin
      sh   = sh_close ? 6 : 13;
      code = int'(sh_ctrl[k][29:28]);
      q    = a >> sh;
      way  = int'(q % (40'd1 << code));
      pre  = (((q >> code)) << sh) | (a & ((40'd1 << sh) - 40'd1));
      off  = {sh_slot[k][way % 4][15:2], 26'd0};
      ra   = pre - off;
      cr   = sh_slot[k][way % 4][19:16];
    end
  endtask

  task automatic lookup(input logic [39:0] a, input string req);
    bit hit; int k; logic [39:0] ra; logic [3:0] cr;
    int cyc;
    model(a, hit, k, ra, cr);
    @(negedge clk);
    start = 1'b1; addr_i = a;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk({req, " R9 latency"}, 64'(cyc), hit ? 64'(k + 3) : 64'd5);
    chk({req, " R8 miss"}, 64'(miss_o), hit ? 64'd0 : 64'd1);
    chk({req, " R6 rank addr"}, 64'(rank_addr_o), 64'(ra));
    chk({req, " R7 chan rank"}, 64'(chan_rank_o), 64'(cr));
    chk({req, " R7 dimm"}, 64'(dimm_o), 64'(cr[3:2]));
    chk({req, " R7 rank"}, 64'(rank_o), 64'(cr[1:0]));
  endtask

  task automatic t_reset();
    chk("R1 done", 64'(done_o), 0);
    chk("R1 miss", 64'(miss_o), 0);
    chk("R1 rank addr", 64'(rank_addr_o), 0);
    chk("R1 chan rank", 64'(chan_rank_o), 0);
    lookup(40'h0000_1234, "R1 empty table");
  endtask

  task automatic t_load();
    wr(2'd0, 0, 0, rng(1, 1, 2));
    wr(2'd0, 1, 0, rng(1, 0, 5));
    wr(2'd0, 2, 0, rng(1, 2, 9));
    wr(2'd0, 3, 0, rng(1, 3, 20));
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 4; w++)
        wr(2'd1, r, w, slot(r, r * 4 + w));
    wr(2'd2, 0, 0, 32'd0);
  endtask

  task automatic t_page_mode();
    lookup(40'h0_1234_5678, "R4 open page R2");
    lookup(40'h0_1234_56F8, "R4 open page way");
    wr(2'd2, 0, 0, 32'd1);
    lookup(40'h0_1234_5678, "R4 close page");
    lookup(40'h0_1234_56F8, "R4 close page way");
    wr(2'd2, 0, 0, 32'd0);
  endtask

  task automatic t_ways();
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 1, 0, rng(1, c, 5));
      lookup(40'h0_7ABC_DE40, "R5 ways sweep");
      lookup(40'h0_7ABC_FE40, "R5 ways sweep b");
      lookup(40'h0_7ABD_BE40, "R5 ways alias");
    end
    wr(2'd0, 1, 0, rng(1, 0, 5));
  endtask

  task automatic t_bounds();
    lookup(40'h0_5FFF_FFFF, "R3 upper inclusive");
    lookup(40'h0_6000_0000, "R3 next entry");
    lookup(40'h0_0000_0000, "R3 zero");
    lookup(40'hFF_FFFF_FFFF, "R8 above all");
    wr(2'd0, 0, 0, rng(0, 1, 2));
    lookup(40'h0_0000_0100, "R3 invalid bound carried");
    lookup(40'h0_5FFF_FFFF, "R3 shared bound");
    wr(2'd0, 0, 0, rng(1, 1, 2));
  endtask

  task automatic t_wrap();
    wr(2'd1, 2, 0, slot(16383, 5));
    wr(2'd1, 2, 1, slot(16383, 6));
    wr(2'd1, 2, 2, slot(16383, 7));
    wr(2'd1, 2, 3, slot(16383, 8));
    lookup(40'h1_0000_2000, "R6 offset wrap");
  endtask

  task automatic t_busy();
    bit hit; int k; logic [39:0] ra; logic [3:0] cr;
    int dones;
    model(40'h3_0000_0040, hit, k, ra, cr);
    @(negedge clk);
    start = 1'b1; addr_i = 40'h3_0000_0040;
    @(negedge clk);
    start = 1'b1; addr_i = 40'h0_0000_0040;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int i = 0; i < 12; i++) begin
      if (done_o) dones++;
      @(negedge clk);
    end
    chk("R10 single done", 64'(dones), 1);
    chk("R10 first result kept", 64'(rank_addr_o), 64'(ra));
    chk("R10 first rank kept", 64'(chan_rank_o), 64'(cr));
    repeat (3) @(negedge clk);
    chk("R11 held rank addr", 64'(rank_addr_o), 64'(ra));
    chk("R11 held done low", 64'(done_o), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_kind = 0; wr_range = 0; wr_way = 0;
    wr_data = 0; start = 1'b0; addr_i = 0;
    for (int r = 0; r < 4; r++) begin
      sh_ctrl[r] = 0;
      for (int w = 0; w < 4; w++) sh_slot[r][w] = 0;
    end
    sh_close = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_page_mode();
    t_ways();
    t_bounds();
    t_wrap();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule